// File: doc/BRIEF.md
# Trigger-Positioned Circular Capture Buffer

This block records a stream of sample words into an on-chip circular memory once it is armed. The point where the trigger falls inside the stored window is set by a post-trigger count. That count runs from zero, where the whole window lies before the trigger, up to the full window length, where the whole window lies after it. Until a trigger is accepted, new qualified samples keep replacing the oldest ones. After the trigger, the buffer stores exactly the post-trigger count of qualified samples and then freezes that window.

The memory can work as one window, in single or repetitive mode, or be cut into 2^k equal segments in segmented mode. In segmented mode each segment captures its own window around its own trigger. For every segment the block keeps the address of its trigger sample and a hit flag, so that a reader can rotate the stored window back into time order. A registered read port gives access to the memory whenever the block is not armed.

The controller is a four-state machine:
- IDLE: waiting.
- PRE: filling, with the trigger allowed once enough samples are stored.
- POST: counting post-trigger samples.
- DONE: capture frozen.

Its transitions are:
- arm takes IDLE or DONE to PRE.
- An accepted trigger takes PRE to POST. When the post count is 0, or it is 1 and the trigger cycle stores a sample, the segment completes at once instead.
- The last post sample completes the segment.
- A completed segment goes to PRE for the next segment, or to DONE after the last one.
- stop takes PRE or POST to DONE in repetitive mode and to IDLE otherwise.

Top module: `cap_buf`

## Requirements
- R1: After reset armed=0, done=0, every trigger-hit bit is 0 and rd_data=0.
- R2: A pulse on arm while not armed enters PRE, clears done, the hit bits and the write position, and latches cfg_mode, cfg_post and cfg_seg_log. An arm pulse while armed is ignored, and a config change while armed has no effect.
- R3: A sample is stored only in a cycle with smp_valid=1 and smp_store=1, and only a stored sample advances the write position.
- R4: Let the segment length be L and the pre-trigger count be L - cfg_post. A trigger is ignored while fewer than that many samples have been stored in the current segment.
- R5: For an accepted trigger, the trigger address is the location where the trigger-cycle sample is written, and that segment's hit bit is set. The buffer then stores exactly cfg_post samples, counting the trigger-cycle sample. With cfg_post=0 the segment completes at the trigger, and the trigger-cycle sample is not stored.
- R6: Before the trigger, writes advance circularly inside the segment, so the oldest sample is overwritten.
- R7: Single mode (cfg_mode=0) reaches DONE after one window. Samples arriving in DONE are not written.
- R8: In repetitive mode (cfg_mode=1) a trigger that completes the window gives done=1. A stop while armed gives done=1 with the hit bit left at 0.
- R9: In single or segmented mode, a stop while armed returns to IDLE with done=0.
- R10: In segmented mode (cfg_mode=2) the memory splits into 2^cfg_seg_log segments of L = DEPTH >> cfg_seg_log words. Segment s starts at address s*L and has its own trigger. Addresses of segment s sit at bits [s*ADDR_W +: ADDR_W] of seg_trig_addr. done rises when the last segment completes.
- R11: When the block is not armed, rd_data holds the word at rd_addr one clock after that address is presented. While armed, rd_data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Start a capture |
| stop | input | 1 | Abort or end a capture |
| cfg_mode | input | 2 | 0 single, 1 repetitive, 2 segmented |
| cfg_post | input | ADDR_W+1 | Post-trigger sample count, 0..L |
| cfg_seg_log | input | $clog2(SEG_LOG_MAX+1) | log2 of the segment count |
| smp_valid | input | 1 | Sample present |
| smp_store | input | 1 | Store qualifier |
| smp_data | input | DATA_W | Sample word |
| trig | input | 1 | Trigger pulse |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | DATA_W | Readback word |
| armed | output | 1 | Capture in progress |
| done | output | 1 | Capture complete |
| seg_hit | output | 2^SEG_LOG_MAX | Trigger accepted per segment |
| seg_trig_addr | output | 2^SEG_LOG_MAX*ADDR_W | Trigger address per segment |

## Verification
The assertions assume that cfg_post never exceeds the segment length and that cfg_seg_log stays within SEG_LOG_MAX when a capture is armed. They also assume that arm and stop are single-cycle pulses whose effect is defined only by the current state. The stimulus loads every configuration before the arm cycle, keeps cfg_post between 0 and L, and issues stop only on its own. Each expected readback word comes from the known order of the stored samples and their modulo-L placement.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    localparam logic [1:0] MODE_SINGLE  = 2'd0;
    localparam logic [1:0] MODE_REPEAT  = 2'd1;
    localparam logic [1:0] MODE_SEGMENT = 2'd2;
endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    // Readback is blanked while a capture is running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= re ? store_q[raddr] : '0;
        end
    end
endmodule

// File: rtl/cap_trig_latch.sv
module cap_trig_latch #(
    parameter int ADDR_W      = 6,
    parameter int SEG_LOG_MAX = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                ld,
    input  logic [SEG_LOG_MAX-1:0]              ld_idx,
    input  logic [ADDR_W-1:0]                   ld_addr,
    output logic [(1<<SEG_LOG_MAX)-1:0]         hit,
    output logic [(1<<SEG_LOG_MAX)*ADDR_W-1:0]  addr
);
    localparam int NSEG = 1 << SEG_LOG_MAX;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit[g]                  <= 1'b0;
                addr[g*ADDR_W +: ADDR_W] <= '0;
            end else if (clr) begin
                hit[g] <= 1'b0;
            end else if (ld && (ld_idx == SEG_LOG_MAX'(g))) begin
                hit[g]                  <= 1'b1;
                addr[g*ADDR_W +: ADDR_W] <= ld_addr;
            end
        end
    end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SEG_LOG_MAX = 2,
    parameter int SLW         = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm,
    input  logic                   stop,
    input  logic [1:0]             cfg_mode,
    input  logic [ADDR_W:0]        cfg_post,
    input  logic [SLW-1:0]         cfg_seg_log,
    input  logic                   smp_valid,
    input  logic                   smp_store,
    input  logic                   trig,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic                   tl_clr,
    output logic                   tl_ld,
    output logic [SEG_LOG_MAX-1:0] tl_idx,
    output logic                   armed,
    output logic                   done
);
    localparam logic [ADDR_W:0] FULL_LEN = (ADDR_W+1)'(1 << ADDR_W);

    cap_state_e             state_q, state_d;
    logic [1:0]             mode_q;
    logic [ADDR_W:0]        post_q;
    logic [SLW-1:0]         slog_q;
    logic [SEG_LOG_MAX-1:0] seg_q;
    logic [ADDR_W-1:0]      off_q;
    logic [ADDR_W:0]        fill_q;
    logic [ADDR_W:0]        pcnt_q;

    logic [SLW-1:0]         slog_eff;
    logic [ADDR_W:0]        seg_len;
    logic [ADDR_W:0]        pre_need;
    logic [ADDR_W-1:0]      off_mask;
    logic [ADDR_W-1:0]      base;
    logic [SEG_LOG_MAX:0]   nseg;
    logic                   last_seg;
    logic                   stored;
    logic                   trig_ok;
    logic                   seg_done;
    logic [ADDR_W:0]        pcnt_inc;
    cap_state_e             stop_tgt;

    // Geometry of the current segment
    always_comb begin
        slog_eff = (mode_q == MODE_SEGMENT) ? slog_q : '0;
        seg_len  = FULL_LEN >> slog_eff;
        pre_need = seg_len - post_q;
        off_mask = seg_len[ADDR_W-1:0] - 1'b1;
        base     = ADDR_W'(seg_q) << (ADDR_W - int'(slog_eff));
        nseg     = (SEG_LOG_MAX+1)'(1) << slog_eff;
        last_seg = ({1'b0, seg_q} == (nseg - 1'b1));
        stored   = smp_valid & smp_store;
        trig_ok  = (state_q == ST_PRE) && trig && (fill_q >= pre_need);
        pcnt_inc = pcnt_q + 1'b1;
        stop_tgt = (mode_q == MODE_REPEAT) ? ST_DONE : ST_IDLE;
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        seg_done = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (arm) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (stop) begin
                    state_d = stop_tgt;
                end else if (trig_ok) begin
                    if ((post_q == '0) || (stored && (post_q == (ADDR_W+1)'(1)))) begin
                        seg_done = 1'b1;
                    end else begin
                        state_d = ST_POST;
                    end
                end
            end
            ST_POST: begin
                if (stop) begin
                    state_d = stop_tgt;
                end else if (stored && (pcnt_inc == post_q)) begin
                    seg_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (seg_done) begin
            state_d = last_seg ? ST_DONE : ST_PRE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        armed   = (state_q == ST_PRE) || (state_q == ST_POST);
        done    = (state_q == ST_DONE);
        wr_en   = stored && !stop &&
                  (((state_q == ST_PRE) && !(trig_ok && (post_q == '0))) ||
                   (state_q == ST_POST));
        wr_addr = base | off_q;
        tl_clr  = arm && !armed;
        tl_ld   = trig_ok && !stop;
        tl_idx  = seg_q;
    end

    // Capture datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SINGLE;
            post_q <= '0;
            slog_q <= '0;
            seg_q  <= '0;
            off_q  <= '0;
            fill_q <= '0;
            pcnt_q <= '0;
        end else if (tl_clr) begin
            mode_q <= cfg_mode;
            post_q <= cfg_post;
            slog_q <= cfg_seg_log;
            seg_q  <= '0;
            off_q  <= '0;
            fill_q <= '0;
            pcnt_q <= '0;
        end else begin
            if (wr_en) begin
                off_q <= (off_q + 1'b1) & off_mask;
                if (fill_q != seg_len) fill_q <= fill_q + 1'b1;
            end
            if (state_q == ST_PRE) begin
                pcnt_q <= (trig_ok && wr_en) ? (ADDR_W+1)'(1) : '0;
            end else if ((state_q == ST_POST) && wr_en) begin
                pcnt_q <= pcnt_inc;
            end
            if (seg_done) begin
                seg_q  <= seg_q + 1'b1;
                off_q  <= '0;
                fill_q <= '0;
                pcnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/cap_buf.sv
module cap_buf #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 6,
    parameter int SEG_LOG_MAX = 2,
    localparam int NSEG       = 1 << SEG_LOG_MAX,
    localparam int SLW        = $clog2(SEG_LOG_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm,
    input  logic                   stop,
    input  logic [1:0]             cfg_mode,
    input  logic [ADDR_W:0]        cfg_post,
    input  logic [SLW-1:0]         cfg_seg_log,
    input  logic                   smp_valid,
    input  logic                   smp_store,
    input  logic [DATA_W-1:0]      smp_data,
    input  logic                   trig,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   armed,
    output logic                   done,
    output logic [NSEG-1:0]        seg_hit,
    output logic [NSEG*ADDR_W-1:0] seg_trig_addr
);
    logic                   wr_en;
    logic [ADDR_W-1:0]      wr_addr;
    logic                   tl_clr;
    logic                   tl_ld;
    logic [SEG_LOG_MAX-1:0] tl_idx;

    cap_ctrl #(
        .ADDR_W(ADDR_W), .SEG_LOG_MAX(SEG_LOG_MAX), .SLW(SLW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop),
        .cfg_mode(cfg_mode), .cfg_post(cfg_post), .cfg_seg_log(cfg_seg_log),
        .smp_valid(smp_valid), .smp_store(smp_store), .trig(trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .tl_clr(tl_clr), .tl_ld(tl_ld),
        .tl_idx(tl_idx), .armed(armed), .done(done)
    );

    cap_mem #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
        .wdata(smp_data), .re(!armed), .raddr(rd_addr), .rdata(rd_data)
    );

    cap_trig_latch #(
        .ADDR_W(ADDR_W), .SEG_LOG_MAX(SEG_LOG_MAX)
    ) i_tlat (
        .clk(clk), .rst_n(rst_n), .clr(tl_clr), .ld(tl_ld),
        .ld_idx(tl_idx), .ld_addr(wr_addr), .hit(seg_hit), .addr(seg_trig_addr)
    );
endmodule

// File: rtl/cap_buf_chk.sv
module cap_buf_chk #(
    parameter int DATA_W = 8,
    parameter int NSEG   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              stop,
    input logic              armed,
    input logic              done,
    input logic [NSEG-1:0]   seg_hit,
    input logic [DATA_W-1:0] rd_data
);
    // R7: a frozen capture is never also running
    assert_done_excl_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && done));

    // R9: stop always ends a running capture
    assert_stop_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stop) |=> !armed);

    // R2: arm from rest starts a capture and clears done
    assert_arm_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && arm) |=> (armed && !done));

    // R11: readback blanked while running
    assert_read_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> (rd_data == '0));

    // R5: trigger records only change during a capture or on arm
    assert_hits_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm) |=> $stable(seg_hit));

    // R8: done only rises out of a running capture
    assert_done_from_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(armed));
endmodule

bind cap_buf cap_buf_chk #(.DATA_W(DATA_W), .NSEG(NSEG)) i_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .armed(armed),
    .done(done), .seg_hit(seg_hit), .rd_data(rd_data)
);

// File: tb/test_cap_buf.sv
module test_cap_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, stop = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [6:0]  cfg_post = 7'd0;
    logic [1:0]  cfg_seg_log = 2'd0;
    logic        smp_valid = 1'b0, smp_store = 1'b0, trig = 1'b0;
    logic [7:0]  smp_data = 8'd0;
    logic [5:0]  rd_addr = 6'd0;
    logic [7:0]  rd_data;
    logic        armed, done;
    logic [3:0]  seg_hit;
    logic [23:0] seg_trig_addr;

    logic        rd_req = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cap_buf i_cap_buf (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .cfg_mode(cfg_mode),
        .cfg_post(cfg_post), .cfg_seg_log(cfg_seg_log), .smp_valid(smp_valid),
        .smp_store(smp_store), .smp_data(smp_data), .trig(trig),
        .rd_addr(rd_addr), .rd_data(rd_data), .armed(armed), .done(done),
        .seg_hit(seg_hit), .seg_trig_addr(seg_trig_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        smp_valid = 0; smp_store = 0; smp_data = 0; trig = 0; arm = 0; stop = 0; rd_req = 0;
    endtask

    // One clock of stimulus; returns just after the edge
    task automatic cyc(input logic v, input logic q, input logic [7:0] d,
                       input logic t, input logic a, input logic s);
        @(negedge clk);
        clear_in();
        smp_valid = v; smp_store = q; smp_data = d; trig = t; arm = a; stop = s;
        @(posedge clk); #1;
    endtask

    // Driver: presents a read and queues the expected word
    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        clear_in();
        rd_addr = a;
        rd_req = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // Monitor: compares the registered read word after the edge
    always @(posedge clk) begin
        #1;
        if (rd_req) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                chk(tag_q.pop_front(), {24'd0, rd_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 armed", armed, 0);
        chk("R1 done", done, 0);
        chk("R1 hits", seg_hit, 0);
        chk("R1 rd_data", rd_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // Single mode, post=16, pre=48
        cfg_mode = 2'd0; cfg_post = 7'd16; cfg_seg_log = 2'd0;
        cyc(0, 0, 0, 0, 1, 0);
        chk("R2 armed after arm", armed, 1);
        rd(6'd0, 8'd0, "R11 read while armed");
        for (int k = 1; k <= 75; k++) begin
            if (k == 31) begin
                cyc(1, 0, 8'hEE, 0, 0, 0);
                cyc(0, 1, 8'hDD, 0, 0, 0);
            end
            cyc(1, 1, 8'(k), (k == 5) || (k == 60), 0, 0);
        end
        chk("R7 single done", done, 1);
        chk("R7 single disarmed", armed, 0);
        chk("R5 hit seg0", seg_hit[0], 1);
        chk("R5 trig addr", seg_trig_addr[5:0], 59);
        cyc(1, 1, 8'hF0, 1, 0, 0);
        rd(6'd59, 8'd60, "R5 trigger sample");
        rd(6'd10, 8'd75, "R5 last post sample");
        rd(6'd11, 8'd12, "R7 no write after done");
        rd(6'd30, 8'd31, "R3 unqualified skipped");
        rd(6'd29, 8'd30, "R3 before gap");
        rd(6'd58, 8'd59, "R4 early trigger ignored");
        rd(6'd0, 8'd65, "R6 oldest overwritten");

        // All-pre: post=0
        cfg_post = 7'd0;
        cyc(0, 0, 0, 0, 1, 0);
        chk("R2 done cleared by arm", done, 0);
        for (int i = 0; i < 64; i++) cyc(1, 1, 8'(100 + i), i == 63, 0, 0);
        chk("R4 trigger before fill ignored", armed, 1);
        cyc(1, 1, 8'hAA, 1, 0, 0);
        chk("R5 all-pre done", done, 1);
        chk("R5 all-pre trig addr", seg_trig_addr[5:0], 0);
        rd(6'd0, 8'd100, "R5 trigger sample not stored");
        rd(6'd63, 8'd163, "R5 all-pre newest");

        // All-post, repetitive: post=64
        cfg_mode = 2'd1; cfg_post = 7'd64;
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 64; i++) cyc(1, 1, 8'(8'h80 + i), i == 0, 0, 0);
        chk("R8 repetitive done by trigger", done, 1);
        chk("R5 all-post hit", seg_hit[0], 1);
        chk("R5 all-post trig addr", seg_trig_addr[5:0], 0);
        rd(6'd0, 8'h80, "R5 all-post first");
        rd(6'd63, 8'hBF, "R5 all-post last");

        // Repetitive without trigger, stop ends it
        cfg_post = 7'd8;
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 80; i++) cyc(1, 1, 8'(i), 0, i == 40, 0);
        chk("R6 still armed while wrapping", armed, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 stop gives done", done, 1);
        chk("R8 no hit", seg_hit[0], 0);
        rd(6'd5, 8'd69, "R6 wrap overwrite");
        rd(6'd20, 8'd20, "R6 not yet overwritten");
        rd(6'd40, 8'd40, "R2 arm while armed ignored");

        // Single mode stop
        cfg_mode = 2'd0;
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 8'(i), 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R9 stop disarms", armed, 0);
        chk("R9 stop no done", done, 0);

        // Segmented: 4 segments of 16, post=4
        cfg_mode = 2'd2; cfg_seg_log = 2'd2; cfg_post = 7'd4;
        cyc(0, 0, 0, 0, 1, 0);
        cfg_mode = 2'd0; cfg_seg_log = 2'd0;
        rd(6'd0, 8'd0, "R11 segmented read while armed");
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j <= 16; j++) begin
                cyc(1, 1, 8'((k << 5) | j), (j == 13) || (k == 0 && j == 5), 0, 0);
            end
            if (k < 3) chk("R10 not done before last segment", done, 0);
        end
        chk("R10 done after last", done, 1);
        chk("R10 all hits", seg_hit, 4'hF);
        for (int k = 0; k < 4; k++) begin
            chk("R10 seg trig addr", seg_trig_addr[k*6 +: 6], 16*k + 13);
            rd(6'(16*k), 8'((k << 5) | 16), "R10 seg wrap post");
            rd(6'(16*k + 1), 8'((k << 5) | 1), "R10 seg pre");
            rd(6'(16*k + 13), 8'((k << 5) | 13), "R10 seg trigger sample");
        end
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule